// File: doc/BRIEF.md
# Bidirectional Splittable Row Scan Register

This block holds the row-select pattern for the common (row) side of a passive-matrix display. A 240-stage shift register advances by one stage each time the line pulse falls, and a direction input picks which way data travels. The same input decides which of the two end pins takes serial data in and which passes it on, so several blocks can be chained in either direction. Exactly one end pin is enabled to drive at any time.

A mode input runs the register either as one 240-stage chain or as two independent 120-stage halves. In split mode the second half takes its data from an auxiliary input, so two row groups scan in parallel. Each stage turns its bit, the frame-inversion input and an active-low blanking input into a 2-bit drive-level code for the analog output stage. While blanking is asserted the register is cleared and will not shift, so after release the rows show the deselect level until the next line pulse loads fresh data.

The design runs from one system clock. The line pulse is sampled by that clock, and a shift happens on the clock edge where the pulse is seen low after being seen high. The serial inputs are sampled on that same edge. Stage index 0 is row 1 and index 239 is row 240.

Top module: `row_scan_reg`

## Requirements
- R1: A synchronous active-high reset clears all stages, so with blanking released and frame inversion low every code reads 2'b10.
- R2: The register shifts only on a clock edge where line_pulse is sampled low after being sampled high on the edge before; a steady high or a steady low line pulse leaves every stage unchanged.
- R3: Single mode (split_mode=0), dir_fwd=0: end_b_in enters row 240, data moves toward row 1, and row 1 appears on end_a_out.
- R4: Single mode, dir_fwd=1: end_a_in enters row 1, data moves toward row 240, and row 240 appears on end_b_out.
- R5: Split mode (split_mode=1), dir_fwd=0: end_b_in enters row 240 and moves toward row 121; aux_in enters row 120 and moves toward row 1; row 1 appears on end_a_out.
- R6: Split mode, dir_fwd=1: end_a_in enters row 1 and moves toward row 120; aux_in enters row 121 and moves toward row 240; row 240 appears on end_b_out.
- R7: In single mode aux_in has no effect on any stage.
- R8: Each stage's code is chosen from {frame_inv, bit}: 00 gives 2'b10, 01 gives 2'b00, 10 gives 2'b01, 11 gives 2'b11 (codes: 2'b00 highest level, 2'b01 upper-middle, 2'b10 lower-middle, 2'b11 lowest level).
- R9: While blank_n is low every code is 2'b11, the register is cleared and line pulses are ignored; after release every row shows the deselect code for the current frame_inv until the next shift.
- R10: end_a_oe is high exactly when dir_fwd is low and end_b_oe is high exactly when dir_fwd is high, so one and only one pin drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pulse | input | 1 | Line pulse; a shift happens on its sampled falling edge |
| dir_fwd | input | 1 | 1: data moves row 1 toward row 240; 0: the reverse |
| split_mode | input | 1 | 1: two 120-stage halves; 0: one 240-stage chain |
| frame_inv | input | 1 | Frame inversion phase |
| blank_n | input | 1 | Active-low blanking; low clears and forces the lowest level |
| end_a_in | input | 1 | Serial input at the row-1 end |
| end_b_in | input | 1 | Serial input at the row-240 end |
| aux_in | input | 1 | Serial input for the second half in split mode |
| end_a_out | output | 1 | Serial output at the row-1 end |
| end_a_oe | output | 1 | Drive enable for the row-1 end pin |
| end_b_out | output | 1 | Serial output at the row-240 end |
| end_b_oe | output | 1 | Drive enable for the row-240 end pin |
| lvl_code | output | 480 | Drive-level code, 2 bits per row, row 1 in bits [1:0] |

## Verification
A shift is due one clock edge after the edge that first samples line_pulse high: the edge detector registers the high level, and the next edge that sees it low moves the chain, so the bench drops the pulse on a falling clock edge and compares the whole row image at the falling edge after the following rising edge. The level codes and pin enables follow frame_inv, blank_n and dir_fwd in the same cycle, so those checks are made half a period after the input change, while clearing by blank_n takes effect at the next rising edge and is checked after it. The bench keeps its own row image updated from the requirement rules and compares all 240 codes after each shift.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

    // Drive levels, highest voltage first
    typedef enum logic [1:0] {
        LVL_TOP  = 2'b00,
        LVL_UMID = 2'b01,
        LVL_LMID = 2'b10,
        LVL_LOW  = 2'b11
    } drive_lvl_e;

    // Chain configuration
    typedef struct packed {
        logic fwd;    // 1: row 1 toward row 240
        logic split;  // 1: two halves
    } scan_cfg_t;

    // Serial feeds into the chain
    typedef struct packed {
        logic lo_in;   // row-1 end
        logic hi_in;   // row-240 end
        logic aux_in;  // second half in split mode
    } scan_feed_t;

    function automatic drive_lvl_e encode_level(
        input logic blank_n,
        input logic inv,
        input logic bit_v
    );
        drive_lvl_e lvl;
        if (!blank_n) begin
            lvl = LVL_LOW;
        end else begin
            unique case ({inv, bit_v})
                2'b00:   lvl = LVL_LMID;
                2'b01:   lvl = LVL_TOP;
                2'b10:   lvl = LVL_UMID;
                default: lvl = LVL_LOW;
            endcase
        end
        return lvl;
    endfunction

endpackage

// File: rtl/rs_edge_detect.sv
module rs_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    output logic fall_o
);
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= pulse_i;
    end

    assign fall_o = pulse_q & ~pulse_i;
endmodule

// File: rtl/rs_scan_chain.sv
module rs_scan_chain
    import row_scan_pkg::*;
#(
    parameter int N_STAGES = 240
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                shift_en,
    input  scan_cfg_t           cfg,
    input  scan_feed_t          feed,
    output logic [N_STAGES-1:0] stage_q
);
    localparam int HALF = N_STAGES / 2;

    logic [N_STAGES-1:0] from_lo;
    logic [N_STAGES-1:0] from_hi;
    logic [N_STAGES-1:0] nxt;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        // Neighbour on the row-1 side (used when moving forward)
        if (i == 0) begin : g_lo_end
            assign from_lo[i] = feed.lo_in;
        end else if (i == HALF) begin : g_lo_split
            assign from_lo[i] = cfg.split ? feed.aux_in : stage_q[i-1];
        end else begin : g_lo_mid
            assign from_lo[i] = stage_q[i-1];
        end

        // Neighbour on the row-240 side (used when moving backward)
        if (i == N_STAGES-1) begin : g_hi_end
            assign from_hi[i] = feed.hi_in;
        end else if (i == HALF-1) begin : g_hi_split
            assign from_hi[i] = cfg.split ? feed.aux_in : stage_q[i+1];
        end else begin : g_hi_mid
            assign from_hi[i] = stage_q[i+1];
        end

        assign nxt[i] = cfg.fwd ? from_lo[i] : from_hi[i];
    end

    always_ff @(posedge clk) begin
        if (rst || clear)  stage_q <= '0;
        else if (shift_en) stage_q <= nxt;
    end
endmodule

// File: rtl/rs_level_enc.sv
module rs_level_enc
    import row_scan_pkg::*;
#(
    parameter int N_STAGES = 240
) (
    input  logic                  blank_n,
    input  logic                  inv,
    input  logic [N_STAGES-1:0]   stage_q,
    output logic [2*N_STAGES-1:0] lvl_code
);
    for (genvar i = 0; i < N_STAGES; i++) begin : g_enc
        assign lvl_code[2*i +: 2] = encode_level(blank_n, inv, stage_q[i]);
    end
endmodule

// File: rtl/row_scan_reg.sv
module row_scan_reg
    import row_scan_pkg::*;
#(
    parameter int N_STAGES = 240
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_pulse,
    input  logic                  dir_fwd,
    input  logic                  split_mode,
    input  logic                  frame_inv,
    input  logic                  blank_n,
    input  logic                  end_a_in,
    input  logic                  end_b_in,
    input  logic                  aux_in,
    output logic                  end_a_out,
    output logic                  end_a_oe,
    output logic                  end_b_out,
    output logic                  end_b_oe,
    output logic [2*N_STAGES-1:0] lvl_code
);
    logic                lp_fall;
    logic                shift_en;
    logic [N_STAGES-1:0] stage_q;
    scan_cfg_t           cfg;
    scan_feed_t          feed;

    assign cfg      = '{fwd: dir_fwd, split: split_mode};
    assign feed     = '{lo_in: end_a_in, hi_in: end_b_in, aux_in: aux_in};
    assign shift_en = lp_fall & blank_n;

    rs_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .pulse_i (line_pulse),
        .fall_o  (lp_fall)
    );

    rs_scan_chain #(.N_STAGES(N_STAGES)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .clear    (~blank_n),
        .shift_en (shift_en),
        .cfg      (cfg),
        .feed     (feed),
        .stage_q  (stage_q)
    );

    rs_level_enc #(.N_STAGES(N_STAGES)) u_enc (
        .blank_n  (blank_n),
        .inv      (frame_inv),
        .stage_q  (stage_q),
        .lvl_code (lvl_code)
    );

    // End pin steering: the downstream end drives
    assign end_a_oe  = ~dir_fwd;
    assign end_b_oe  = dir_fwd;
    assign end_a_out = ~dir_fwd & stage_q[0];
    assign end_b_out = dir_fwd & stage_q[N_STAGES-1];
endmodule

// File: rtl/row_scan_chk.sv
module row_scan_chk #(
    parameter int N_STAGES = 240
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  line_pulse,
    input logic                  dir_fwd,
    input logic                  split_mode,
    input logic                  blank_n,
    input logic                  end_a_in,
    input logic                  end_b_in,
    input logic                  aux_in,
    input logic                  end_a_oe,
    input logic                  end_b_oe,
    input logic [2*N_STAGES-1:0] lvl_code,
    input logic [N_STAGES-1:0]   stage_q,
    input logic                  lp_fall,
    input logic                  shift_en
);
    localparam int HALF = N_STAGES / 2;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> stage_q == '0);

    // R2
    fall_detect_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(line_pulse) && !line_pulse) |-> lp_fall);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_n && !lp_fall) |=> $stable(stage_q));

    // R3
    back_single_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !dir_fwd && !split_mode) |=>
        (stage_q[N_STAGES-2:0] == $past(stage_q[N_STAGES-1:1])) &&
        (stage_q[N_STAGES-1] == $past(end_b_in)));

    // R4
    fwd_single_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && dir_fwd && !split_mode) |=>
        (stage_q[N_STAGES-1:1] == $past(stage_q[N_STAGES-2:0])) &&
        (stage_q[0] == $past(end_a_in)));

    // R5
    back_split_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !dir_fwd && split_mode) |=>
        (stage_q[HALF-1] == $past(aux_in)) &&
        (stage_q[N_STAGES-1] == $past(end_b_in)));

    // R6
    fwd_split_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && dir_fwd && split_mode) |=>
        (stage_q[HALF] == $past(aux_in)) && (stage_q[0] == $past(end_a_in)));

    // R9
    blank_low_chk: assert property (@(posedge clk) disable iff (rst)
        !blank_n |-> (lvl_code == {N_STAGES{2'b11}}));

    // R9
    blank_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !blank_n |=> stage_q == '0);

    // R10
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({end_a_oe, end_b_oe}) && (end_b_oe == dir_fwd));
endmodule

bind row_scan_reg row_scan_chk #(.N_STAGES(N_STAGES)) u_row_scan_chk (
    .clk        (clk),
    .rst        (rst),
    .line_pulse (line_pulse),
    .dir_fwd    (dir_fwd),
    .split_mode (split_mode),
    .blank_n    (blank_n),
    .end_a_in   (end_a_in),
    .end_b_in   (end_b_in),
    .aux_in     (aux_in),
    .end_a_oe   (end_a_oe),
    .end_b_oe   (end_b_oe),
    .lvl_code   (lvl_code),
    .stage_q    (stage_q),
    .lp_fall    (lp_fall),
    .shift_en   (shift_en)
);

// File: tb/row_scan_reg_bench.sv
module row_scan_reg_bench;
    localparam int N = 240;
    localparam int H = N / 2;

    // {frame_inv, blank_n, code for a 1-stage, code for a 0-stage}
    localparam logic [5:0] ENC_TAB [0:3] = '{
        6'b0_1_00_10,
        6'b1_1_11_01,
        6'b0_0_11_11,
        6'b1_0_11_11
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           line_pulse = 1'b0;
    logic           dir_fwd = 1'b0;
    logic           split_mode = 1'b0;
    logic           frame_inv = 1'b0;
    logic           blank_n = 1'b1;
    logic           end_a_in = 1'b0;
    logic           end_b_in = 1'b0;
    logic           aux_in = 1'b0;
    logic           end_a_out, end_a_oe, end_b_out, end_b_oe;
    logic [2*N-1:0] lvl_code;

    logic [N-1:0]   model = '0;
    int             checks = 0;
    int             errors = 0;
    bit             done = 1'b0;

    always #2 clk = ~clk;

    row_scan_reg #(.N_STAGES(N)) u_row_scan_reg (
        .clk(clk), .rst(rst), .line_pulse(line_pulse), .dir_fwd(dir_fwd),
        .split_mode(split_mode), .frame_inv(frame_inv), .blank_n(blank_n),
        .end_a_in(end_a_in), .end_b_in(end_b_in), .aux_in(aux_in),
        .end_a_out(end_a_out), .end_a_oe(end_a_oe), .end_b_out(end_b_out),
        .end_b_oe(end_b_oe), .lvl_code(lvl_code)
    );

    function automatic logic [1:0] exp_code(input logic b);
        if (!blank_n) return 2'b11;
        case ({frame_inv, b})
            2'b00:   return 2'b10;
            2'b01:   return 2'b00;
            2'b10:   return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    task automatic check_all(input string req);
        int bad = -1;
        checks++;
        for (int i = 0; i < N; i++)
            if (bad < 0 && lvl_code[2*i +: 2] !== exp_code(model[i])) bad = i;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s row %0d: got %b expected %b", req, bad + 1,
                     lvl_code[2*bad +: 2], exp_code(model[bad]));
        end
    endtask

    task automatic check1(input string req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic model_step(input logic a, input logic b, input logic x);
        logic [N-1:0] old = model;
        if (!blank_n) begin
            model = '0;
        end else if (!dir_fwd) begin
            for (int i = 0; i < N-1; i++) model[i] = old[i+1];
            model[N-1] = b;
            if (split_mode) model[H-1] = x;
        end else begin
            for (int i = 1; i < N; i++) model[i] = old[i-1];
            model[0] = a;
            if (split_mode) model[H] = x;
        end
    endtask

    // One line pulse; returns at the falling clock edge after the shift
    task automatic do_shift(input logic a, input logic b, input logic x);
        @(negedge clk);
        end_a_in = a; end_b_in = b; aux_in = x; line_pulse = 1'b1;
        @(negedge clk);
        line_pulse = 1'b0;
        @(posedge clk);
        model_step(a, b, x);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_all("R1");
        // R10 pin enables, backward direction
        check1("R10", {end_a_oe, end_b_oe}, 2'b10);

        // R3 single backward, R7 aux toggled but ignored
        for (int k = 0; k < 10; k++) begin
            do_shift(1'b1, (k % 3) == 0, k[0]);
            check_all("R3/R7");
        end
        check1("R3 end_a_out", {1'b0, end_a_out}, {1'b0, model[0]});

        // R2 steady high line pulse: no shift
        @(negedge clk);
        end_b_in = 1'b1; line_pulse = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R2 steady high");
        line_pulse = 1'b0;
        @(posedge clk);
        model_step(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check_all("R2 fall");
        repeat (6) @(negedge clk);
        check_all("R2 steady low");

        // R4 single forward
        dir_fwd = 1'b1;
        @(negedge clk);
        check1("R10", {end_a_oe, end_b_oe}, 2'b01);
        for (int k = 0; k < 6; k++) begin
            do_shift(k[0], 1'b0, 1'b1);
            check_all("R4/R7");
        end
        check1("R4 end_b_out", {1'b0, end_b_out}, {1'b0, model[N-1]});

        // R6 split forward
        split_mode = 1'b1;
        for (int k = 0; k < 5; k++) begin
            do_shift(1'b1, 1'b0, k[1]);
            check_all("R6");
        end

        // R5 split backward: fill the lower half from aux
        dir_fwd = 1'b0;
        for (int k = 0; k < H; k++) begin
            do_shift(1'b1, 1'b0, 1'b1);
            if (k % 40 == 0) check_all("R5");
        end
        check_all("R5 filled");
        check1("R5 end_a_out", {1'b0, end_a_out}, 2'b01);

        // R8 encoding table (blanking entries last, they clear the chain)
        for (int e = 0; e < 4; e++) begin
            @(negedge clk);
            frame_inv = ENC_TAB[e][5];
            blank_n   = ENC_TAB[e][4];
            @(posedge clk);
            #1;
            check1("R8 one-row", lvl_code[1:0], ENC_TAB[e][3:2]);
            check1("R8 zero-row", lvl_code[2*N-1 -: 2], ENC_TAB[e][1:0]);
        end
        model = '0;

        // R9 pulses during blanking are ignored
        do_shift(1'b1, 1'b1, 1'b1);
        check_all("R9 blank pulse");
        @(negedge clk);
        blank_n = 1'b1; frame_inv = 1'b0;
        @(negedge clk);
        check_all("R9 deselect");
        check1("R9 deselect row1", lvl_code[1:0], 2'b10);
        frame_inv = 1'b1;
        @(negedge clk);
        check1("R9 deselect inv", lvl_code[1:0], 2'b01);
        split_mode = 1'b0;
        do_shift(1'b0, 1'b1, 1'b0);
        check_all("R9 reload");
        check1("R9 row240", lvl_code[2*N-1 -: 2], 2'b11);

        finish_run();
    end
endmodule